// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block is the eight-bit control and status register that collects interrupt requests for a small microcontroller core. It holds one request flag for each of two external interrupt pins and each of two timer overflow sources. For each external pin it also holds a trigger-select bit, and it holds a run bit for each timer. Software can rewrite the register as a whole byte, or one bit at a time through a bit-addressable window. The current contents are always visible on a read port.

An external pin is active low. Its trigger-select bit picks one of two modes. In low-level mode the request flag simply follows the synchronized, inverted pin. In falling-edge mode a detected high-to-low transition sets the flag, and the flag then stays set until it is cleared. Timer flags are set by a one-cycle overflow pulse from the timer. A flag that latches its event (a timer flag, or an external flag in edge mode) is cleared by the matching vector-acknowledge strobe from the core, or by a software write. The four flags drive the request outputs.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset the read port returns 0x00, all request outputs are 0 and both timer run outputs are 0.
- R2: The bits, MSB first, are: timer1 flag (7), timer1 run (6), timer0 flag (5), timer0 run (4), ext1 flag (3), ext1 trigger-select (2), ext0 flag (1), ext0 trigger-select (0). A byte write loads the register on the next clock edge. The run outputs equal bits 6 and 4.
- R3: A bit write to address BASE_ADDR+k (k = 0..7) loads only bit k on the next edge. Bit writes to addresses outside that range leave the register unchanged.
- R4: When trigger-select is 0 (low-level mode), the ext flag equals the inverted pin delayed by SYNC_STAGES+1 edges. Vector acknowledges and software writes do not change it.
- R5: When trigger-select is 1 (falling-edge mode), a synchronized high sample followed by a low sample sets the ext flag. A pin held low does not set the flag again after it has been cleared.
- R6: In edge mode, the ext vector acknowledge clears the ext flag, and a software write of 1 or 0 sets or clears it.
- R7: A timer overflow pulse sets the timer flag on the next edge. The timer acknowledge clears it.
- R8: A set event and an acknowledge in the same cycle leave the flag set.
- R9: A set event and a software write of 0 to that flag in the same cycle leave the flag set.
- R10: irq_req[0..3] equals read bits 1, 3, 5, 7 (ext0, ext1, timer0, timer1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Whole-register write strobe |
| wr_byte_data | input | 8 | Whole-register write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_addr | input | ADDR_W | Single-bit write address |
| wr_bit_val | input | 1 | Single-bit write value |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ack_ext | input | 2 | External interrupt vector acknowledges |
| ack_tmr | input | 2 | Timer interrupt vector acknowledges |
| rd_data | output | 8 | Current register contents |
| irq_req | output | 4 | Request outputs {tmr1, tmr0, ext1, ext0} |
| tmr_run | output | 2 | Timer run enables {tmr1, tmr0} |

## Verification
The bench builds the block with its defaults: a bit window based at 0x88 with an eight-bit address, two synchronizer stages and two reset-release stages. With these values the pin-to-flag latency is exactly three edges, so the bench can place an acknowledge or a software clear on the very edge where a falling edge lands. That brings the set-wins cases within reach. The fixed base also lets the bench aim bit writes just below and just above the eight-address window.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned N_EXT = 2;
  localparam int unsigned N_TMR = 2;

  // control bit k of the plain (non-flag) group sits at register bit 2k
  function automatic int unsigned ctl_pos(int unsigned k);
    return 2 * k;
  endfunction

  function automatic int unsigned ext_flag_pos(int unsigned i);
    return 1 + 2 * i;
  endfunction

  function automatic int unsigned tmr_flag_pos(int unsigned i);
    return 5 + 2 * i;
  endfunction
endpackage

// File: rtl/irqf_rst_sync.sv
module irqf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/irqf_ext_chan.sv
module irqf_ext_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic sw_we,
  input  logic sw_val,
  input  logic ack,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;
  logic flag_q, flag_d;
  logic synced, fall;

  assign synced = sync_q[SYNC_STAGES-1];
  assign fall   = prev_q & ~synced;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_n};
    if (!edge_mode)  flag_d = ~synced;
    else if (fall)   flag_d = 1'b1;
    else if (sw_we)  flag_d = sw_val;
    else if (ack)    flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= synced;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h88,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_byte_en,
  input  logic [7:0]        wr_byte_data,
  input  logic              wr_bit_en,
  input  logic [ADDR_W-1:0] wr_bit_addr,
  input  logic              wr_bit_val,
  input  logic [1:0]        ext_n,
  input  logic [1:0]        tmr_ovf,
  input  logic [1:0]        ack_ext,
  input  logic [1:0]        ack_tmr,
  output logic [7:0]        rd_data,
  output logic [3:0]        irq_req,
  output logic [1:0]        tmr_run
);
  localparam int unsigned IDX_W = $clog2(REG_W);
  localparam int unsigned N_CTL = REG_W / 2;

  logic rst_int_n;
  logic bit_hit;
  logic [IDX_W-1:0] bit_idx;
  logic [REG_W-1:0] sw_we, sw_val;
  logic [N_CTL-1:0] ctl_q, ctl_d;
  logic [N_TMR-1:0] tf_q, tf_d;
  logic [N_EXT-1:0] ext_flag;

  irqf_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  // software write merge: a bit write overrides the byte write on its bit
  assign bit_hit = wr_bit_en && (wr_bit_addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
  assign bit_idx = wr_bit_addr[IDX_W-1:0];

  always_comb begin
    sw_we  = {REG_W{wr_byte_en}};
    sw_val = wr_byte_data;
    if (bit_hit) begin
      sw_we[bit_idx]  = 1'b1;
      sw_val[bit_idx] = wr_bit_val;
    end
  end

  // plain control bits: trigger selects and run bits
  always_comb begin
    for (int k = 0; k < N_CTL; k++) begin
      ctl_d[k] = sw_we[ctl_pos(k)] ? sw_val[ctl_pos(k)] : ctl_q[k];
    end
  end

  // timer flags: set beats software write beats acknowledge
  always_comb begin
    for (int i = 0; i < N_TMR; i++) begin
      if (tmr_ovf[i])                 tf_d[i] = 1'b1;
      else if (sw_we[tmr_flag_pos(i)]) tf_d[i] = sw_val[tmr_flag_pos(i)];
      else if (ack_tmr[i])            tf_d[i] = 1'b0;
      else                            tf_d[i] = tf_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q <= '0;
      tf_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      tf_q  <= tf_d;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irqf_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) chan_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .pin_n    (ext_n[g]),
      .edge_mode(ctl_q[g]),
      .sw_we    (sw_we[ext_flag_pos(g)]),
      .sw_val   (sw_val[ext_flag_pos(g)]),
      .ack      (ack_ext[g]),
      .flag     (ext_flag[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_CTL; k++) rd_data[ctl_pos(k)] = ctl_q[k];
    for (int i = 0; i < N_EXT; i++) rd_data[ext_flag_pos(i)] = ext_flag[i];
    for (int i = 0; i < N_TMR; i++) rd_data[tmr_flag_pos(i)] = tf_q[i];
  end

  assign irq_req = {tf_q, ext_flag};
  assign tmr_run = ctl_q[N_CTL-1:N_EXT];
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h88
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_byte_en,
  input logic [3:0]        byte_ctl,
  input logic [1:0]        byte_tf,
  input logic              wr_bit_en,
  input logic [ADDR_W-1:0] wr_bit_addr,
  input logic [1:0]        tmr_ovf,
  input logic [1:0]        ack_tmr,
  input logic [7:0]        rd_data,
  input logic [3:0]        irq_req,
  input logic [1:0]        tmr_run
);
  logic sw_tf0, sw_tf1;
  assign sw_tf0 = wr_byte_en || (wr_bit_en && wr_bit_addr == BASE_ADDR + 5);
  assign sw_tf1 = wr_byte_en || (wr_bit_en && wr_bit_addr == BASE_ADDR + 7);

  assert_run_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run == {rd_data[6], rd_data[4]});

  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_en && !wr_bit_en) |=> {rd_data[6], rd_data[4], rd_data[2], rd_data[0]} == $past(byte_ctl));

  assert_req_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == {rd_data[7], rd_data[5], rd_data[3], rd_data[1]});

  assert_tmr0_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf[0] |=> rd_data[5]);

  assert_tmr1_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[1] && ack_tmr[1]) |=> rd_data[7]);

  assert_tmr0_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr[0] && !tmr_ovf[0] && !sw_tf0) |=> !rd_data[5]);

  assert_tmr1_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr[1] && !tmr_ovf[1] && !sw_tf1) |=> !rd_data[7]);

  assert_set_over_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[0] && wr_byte_en && !byte_tf[0]) |=> rd_data[5]);

  assert_set_over_write1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[1] && wr_byte_en && !byte_tf[1]) |=> rd_data[7]);
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .wr_byte_en (wr_byte_en),
  .byte_ctl   ({wr_byte_data[6], wr_byte_data[4], wr_byte_data[2], wr_byte_data[0]}),
  .byte_tf    ({wr_byte_data[7], wr_byte_data[5]}),
  .wr_bit_en  (wr_bit_en),
  .wr_bit_addr(wr_bit_addr),
  .tmr_ovf    (tmr_ovf),
  .ack_tmr    (ack_tmr),
  .rd_data    (rd_data),
  .irq_req    (irq_req),
  .tmr_run    (tmr_run)
);

// File: tb/irq_flag_reg_tb_top.sv
module irq_flag_reg_tb_top;
  localparam logic [7:0] BASE = 8'h88;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_byte_en, wr_bit_en, wr_bit_val;
  logic [7:0] wr_byte_data, wr_bit_addr;
  logic [1:0] ext_n, tmr_ovf, ack_ext, ack_tmr;
  logic [7:0] rd_data;
  logic [3:0] irq_req;
  logic [1:0] tmr_run;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_addr(wr_bit_addr), .wr_bit_val(wr_bit_val),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ack_ext(ack_ext), .ack_tmr(ack_tmr),
    .rd_data(rd_data), .irq_req(irq_req), .tmr_run(tmr_run)
  );

  // {byte_en, byte_data[8], ovf{t1,t0}, ack{t1,t0,e1,e0}, pad[9], expected rd[8]}
  localparam logic [31:0] VEC [12] = '{
    {1'b1, 8'h55, 2'b00, 4'b0000, 9'd0, 8'h55},  // R2 load controls
    {1'b0, 8'h00, 2'b01, 4'b0000, 9'd0, 8'h75},  // R7 tmr0 set
    {1'b0, 8'h00, 2'b10, 4'b0100, 9'd0, 8'hD5},  // R7 tmr1 set, tmr0 ack
    {1'b0, 8'h00, 2'b10, 4'b1000, 9'd0, 8'hD5},  // R8 set beats ack
    {1'b1, 8'h00, 2'b01, 4'b0000, 9'd0, 8'h20},  // R9 set beats write 0
    {1'b1, 8'hAA, 2'b00, 4'b0000, 9'd0, 8'hA0},  // R4 level flags ignore write
    {1'b0, 8'h00, 2'b00, 4'b1100, 9'd0, 8'h00},  // R7 both acks
    {1'b1, 8'h0F, 2'b00, 4'b0000, 9'd0, 8'h05},  // R4 still level on this edge
    {1'b1, 8'h0F, 2'b00, 4'b0000, 9'd0, 8'h0F},  // R6 edge mode write 1
    {1'b0, 8'h00, 2'b00, 4'b0011, 9'd0, 8'h05},  // R6 ext acks
    {1'b0, 8'h00, 2'b11, 4'b1100, 9'd0, 8'hA5},  // R8 both set beat acks
    {1'b1, 8'h00, 2'b00, 4'b0000, 9'd0, 8'h00}   // R2 clear all
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bit_wr(input logic [7:0] a, input logic v);
    wr_bit_en = 1'b1; wr_bit_addr = a; wr_bit_val = v;
    tick(1);
    wr_bit_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    wr_byte_en = 1'b0; wr_byte_data = '0;
    wr_bit_en = 1'b0; wr_bit_addr = '0; wr_bit_val = 1'b0;
    ext_n = 2'b11; tmr_ovf = '0; ack_ext = '0; ack_tmr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 irq", irq_req, 4'h0);
    chk("R1 run", tmr_run, 2'b00);

    for (int v = 0; v < 12; v++) begin
      wr_byte_en   = VEC[v][31];
      wr_byte_data = VEC[v][30:23];
      tmr_ovf      = VEC[v][22:21];
      ack_tmr      = VEC[v][20:19];
      ack_ext      = VEC[v][18:17];
      tick(1);
      chk($sformatf("R2/R7 vec%0d rd", v), rd_data, VEC[v][7:0]);
      chk($sformatf("R10 vec%0d irq", v), irq_req,
          {VEC[v][7], VEC[v][5], VEC[v][3], VEC[v][1]});
    end
    wr_byte_en = 1'b0; tmr_ovf = '0; ack_tmr = '0; ack_ext = '0;

    // R3 bit window
    bit_wr(BASE + 8'd6, 1'b1);
    chk("R3 bit6 set", rd_data, 8'h40);
    chk("R2 run out", tmr_run, 2'b10);
    bit_wr(BASE + 8'd8, 1'b1);
    chk("R3 above window", rd_data, 8'h40);
    bit_wr(BASE - 8'd1, 1'b1);
    chk("R3 below window", rd_data, 8'h40);
    bit_wr(BASE + 8'd6, 1'b0);
    chk("R3 bit6 clear", rd_data, 8'h00);

    // R4 level mode on ext0
    ext_n = 2'b10;
    tick(2);
    chk("R4 latency", rd_data[1], 1'b0);
    tick(1);
    chk("R4 level follows", rd_data[1], 1'b1);
    chk("R10 ext0 req", irq_req[0], 1'b1);
    ack_ext = 2'b01;
    bit_wr(BASE + 8'd1, 1'b0);
    ack_ext = 2'b00;
    chk("R4 ack/write ignored", rd_data[1], 1'b1);
    ext_n = 2'b11;
    tick(3);
    chk("R4 level release", rd_data[1], 1'b0);
    ext_n = 2'b01;
    tick(3);
    chk("R4 ext1 level", irq_req, 4'b0010);
    ext_n = 2'b11;
    tick(3);
    chk("R4 ext1 release", irq_req, 4'b0000);

    // R5/R6 edge mode on ext0
    bit_wr(BASE + 8'd0, 1'b1);
    chk("R5 edge mode on", rd_data, 8'h01);
    ext_n = 2'b10;
    tick(2);
    chk("R5 latency", rd_data[1], 1'b0);
    tick(1);
    chk("R5 fall sets", rd_data[1], 1'b1);
    ack_ext = 2'b01;
    tick(1);
    ack_ext = 2'b00;
    chk("R6 ack clears", rd_data[1], 1'b0);
    tick(5);
    chk("R5 held low no reset", rd_data[1], 1'b0);
    ext_n = 2'b11;
    tick(3);
    bit_wr(BASE + 8'd1, 1'b1);
    chk("R6 sw set", rd_data, 8'h03);
    wr_byte_en = 1'b1; wr_byte_data = 8'h01;
    tick(1);
    wr_byte_en = 1'b0;
    chk("R6 sw clear", rd_data, 8'h01);

    // R8 edge set coincides with ack
    ext_n = 2'b10;
    tick(2);
    ack_ext = 2'b01;
    tick(1);
    ack_ext = 2'b00;
    chk("R8 ext set beats ack", rd_data[1], 1'b1);
    ext_n = 2'b11;
    ack_ext = 2'b01;
    tick(1);
    ack_ext = 2'b00;
    tick(3);
    chk("R6 cleared", rd_data[1], 1'b0);

    // R9 edge set coincides with software write 0
    ext_n = 2'b10;
    tick(2);
    bit_wr(BASE + 8'd1, 1'b0);
    chk("R9 ext set beats write", rd_data[1], 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule